// File: doc/BRIEF.md
# Event Counting Timer with Compare Match

This block is one timer channel that counts timer clocks and raises a sticky flag when the running count equals a programmed compare value. A timer clock is either one active edge of an external event pin or one cycle of an internal prescaler tick. The event pin is passed through a two-stage synchronizer before its edges are detected. A control bit selects whether rising or falling edges count.

Software programs the block through a small register port. It writes a load value, a compare value and a control word, then enables the channel. Enabling copies the load value into the counter. After a match, the counter does one of two things, depending on a control bit. Either it is refilled with the load value on the next timer clock, or it keeps counting upward and wraps at its full width. The interrupt output is the compare flag gated by an enable bit.

Register map (addr): 0 control, 1 status, 2 load, 3 compare, 4 counter (read only). Control fields: bit 0 enable, bits 4:1 mode, bit 5 invert, bit 6 reload, bit 7 interrupt enable, bit 8 source (0 = event pin, 1 = prescaler tick). Status: bit 0 compare flag.

Top module: `evt_cmp_timer`

## Requirements
- R1: After reset, every register reads 0 (control, status, load, compare, counter), and irq is 0.
- R2: The channel is active only when control bit 0 is 1 and bits 4:1 equal 4'b0011. A control write that makes an idle channel active copies the load register into the counter. A control write to a channel that is already active does not change the counter.
- R3: With source 0 and invert 0, each rising edge of evt_pin adds one to the counter, after a two-flop synchronizer. A high level with no new edge adds nothing.
- R4: With source 0 and invert 1, only falling edges of evt_pin count, and rising edges have no effect.
- R5: With source 1, each cycle in which presc_tick is high counts once, and evt_pin has no effect.
- R6: When a timer clock makes the counter equal the compare register, status bit 0 becomes 1. It stays 1 until status is written with bit 0 = 1. Writing status with bit 0 = 0 leaves it set. The flag is set only on a timer clock.
- R7: irq is 1 exactly when status bit 0 is 1 and control bit 7 is 1.
- R8: With reload bit 6 = 1, load N and compare M > N, the first match comes M−N timer clocks after enable. The next timer clock reloads N, and later matches recur every M−N+1 timer clocks.
- R9: With reload bit 6 = 0, the counter keeps incrementing after a match and wraps from all ones to 0.
- R10: While the channel is inactive, the counter holds its value and the flag is not set by any input.
- R11: With enable = 1 and a mode other than 4'b0011, no input changes the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 24 | Write data |
| rdata | output | 24 | Read data for addr (combinational) |
| evt_pin | input | 1 | Asynchronous external event input |
| presc_tick | input | 1 | One-cycle tick from the prescaler |
| irq | output | 1 | Compare interrupt request |

## Verification
Some properties are checked on every cycle. While the channel is inactive, the counter holds. A timer clock either adds exactly one or, when a reload is pending, loads the load value. The flag stays set until a clear write, and it can only rise on a timer clock. Other behaviour can only be shown by the bench scenarios. These are the edge polarity through the synchronizer, the pin being ignored when the prescaler is selected, the M−N and M−N+1 match spacing, wrap-around, and the effect of a non-matching mode field.

// File: rtl/evt_cmp_timer.sv
module evt_cmp_timer #(
  parameter int W    = 24,
  parameter int SYNC = 2,
  parameter int AW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic          evt_pin,
  input  logic          presc_tick,
  output logic          irq
);
  localparam int CW = 9;
  localparam logic [3:0] EVT_MODE = 4'b0011;

  logic [CW-1:0]   ctrl;
  logic [W-1:0]    load_r, cmp_r, cnt;
  logic            flag, pend, pin_q;
  logic [SYNC-1:0] sync;

  wire en   = ctrl[0];
  wire inv  = ctrl[5];
  wire trm  = ctrl[6];
  wire ie   = ctrl[7];
  wire src  = ctrl[8];
  wire active = en && (ctrl[4:1] == EVT_MODE);

  wire wr_ctrl = wr_en && (addr == AW'(0));
  wire wr_stat = wr_en && (addr == AW'(1));
  wire wr_load = wr_en && (addr == AW'(2));
  wire wr_cmp  = wr_en && (addr == AW'(3));

  wire pin_s    = sync[SYNC-1];
  wire pin_edge = inv ? (pin_q & ~pin_s) : (~pin_q & pin_s);
  wire tclk     = active && (src ? presc_tick : pin_edge);
  wire start    = wr_ctrl && wdata[0] && (wdata[4:1] == EVT_MODE) && !active;
  wire do_rel   = trm && pend;
  wire [W-1:0] cnt_nxt = do_rel ? load_r : cnt + W'(1);
  wire hit      = tclk && (cnt_nxt == cmp_r);

  assign irq = flag && ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync  <= '0;
      pin_q <= 1'b0;
    end else begin
      sync  <= {sync[SYNC-2:0], evt_pin};
      pin_q <= pin_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      load_r <= '0;
      cmp_r  <= '0;
    end else begin
      if (wr_ctrl) ctrl   <= wdata[CW-1:0];
      if (wr_load) load_r <= wdata;
      if (wr_cmp)  cmp_r  <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (start) begin
      cnt  <= load_r;
      pend <= 1'b0;
    end else if (tclk) begin
      cnt  <= cnt_nxt;
      pend <= hit && trm;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  flag <= 1'b0;
    else if (hit)                flag <= 1'b1;
    else if (wr_stat && wdata[0]) flag <= 1'b0;
  end

  always_comb begin
    case (addr)
      AW'(0):  rdata = W'(ctrl);
      AW'(1):  rdata = W'(flag);
      AW'(2):  rdata = load_r;
      AW'(3):  rdata = cmp_r;
      AW'(4):  rdata = cnt;
      default: rdata = '0;
    endcase
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> $stable(cnt));
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr_stat && wdata[0])) |=> flag);
  assert_flag_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tclk));
  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tclk && do_rel) |=> (cnt == $past(load_r)));
  assert_incr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tclk && !do_rel) |=> (cnt == $past(cnt) + W'(1)));
endmodule

// File: tb/evt_cmp_timer_tb.sv
module evt_cmp_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] BASE = 24'h007, INV = 24'h020, TRM = 24'h040,
                          IE = 24'h080, SRC = 24'h100;

  logic clk = 0, rst_n = 0, wr_en = 0, evt_pin = 0, presc_tick = 0;
  logic [2:0] addr = 0;
  logic [23:0] wdata = 0, rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  evt_cmp_timer dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_pin(evt_pin), .presc_tick(presc_tick), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic chk(input logic [2:0] a, input logic [23:0] exp, input string tag);
    addr = a; #1;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s addr %0d: got %h expected %h", tag, a, rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq: got %b expected %b", tag, irq, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); presc_tick = 1;
      @(negedge clk); presc_tick = 0;
    end
  endtask

  task automatic pin(input logic v);
    @(negedge clk); evt_pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 5; a++) chk(3'(a), 24'h0, "R1");
    chk_irq(0, "R1");
  endtask

  task automatic t_pin_rise;
    wr(2, 24'd10); wr(3, 24'd100); wr(0, BASE);
    chk(4, 24'd10, "R2 load on enable");
    for (int i = 0; i < 3; i++) begin pin(1); pin(0); end
    chk(4, 24'd13, "R3 rising edges");
    wr(0, BASE | IE);
    chk(4, 24'd13, "R2 rewrite while active");
  endtask

  task automatic t_pin_fall;
    wr(0, 24'h0);
    pin(1); pin(0);
    chk(4, 24'd13, "R10 inactive hold");
    wr(0, BASE | INV);
    chk(4, 24'd10, "R2 reload on re-enable");
    pin(1);
    chk(4, 24'd10, "R4 rising ignored");
    pin(0);
    chk(4, 24'd11, "R4 falling counts");
  endtask

  task automatic t_presc;
    wr(0, 24'h0); wr(0, BASE | SRC | INV);
    pin(1); pin(0);
    chk(4, 24'd10, "R5 pin ignored");
    tick(5);
    chk(4, 24'd15, "R5 prescaler ticks");
  endtask

  task automatic t_reload;
    wr(0, 24'h0); wr(2, 24'd5); wr(3, 24'd8);
    wr(0, BASE | SRC | TRM | IE);
    tick(2);
    chk(1, 24'd0, "R8 no early match");
    tick(1);
    chk(4, 24'd8, "R8 count at match");
    chk(1, 24'd1, "R6 flag set");
    chk_irq(1, "R7 irq with enable");
    wr(1, 24'd0);
    chk(1, 24'd1, "R6 write 0 keeps flag");
    wr(1, 24'd1);
    chk(1, 24'd0, "R6 w1c clear");
    chk_irq(0, "R7 irq drops");
    tick(1);
    chk(4, 24'd5, "R8 reload on next clock");
    tick(2);
    chk(1, 24'd0, "R8 no match before M-N+1");
    tick(1);
    chk(1, 24'd1, "R8 match after M-N+1");
  endtask

  task automatic t_norel;
    wr(0, 24'h0); wr(1, 24'd1);
    wr(2, 24'hFFFFFE); wr(3, 24'hFFFFFF);
    wr(0, BASE | SRC);
    tick(1);
    chk(1, 24'd1, "R9 match");
    chk_irq(0, "R7 irq masked");
    wr(1, 24'd1);
    tick(1);
    chk(4, 24'h000000, "R9 wrap");
    tick(1);
    chk(4, 24'h000001, "R9 keeps counting");
    chk(1, 24'd0, "R9 no extra match");
  endtask

  task automatic t_disable;
    wr(0, SRC | 24'h006);
    wr(3, 24'd2);
    tick(3);
    chk(4, 24'd1, "R10 count held");
    chk(1, 24'd0, "R10 no flag");
  endtask

  task automatic t_mode;
    wr(0, SRC | 24'h00B);
    tick(3); pin(1); pin(0);
    chk(4, 24'd1, "R11 other mode");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_pin_rise; t_pin_fall; t_presc;
    t_reload; t_norel; t_disable; t_mode;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule